// File: doc/BRIEF.md
# Pulse-Count Phrase Select Interface

This block decodes a two-wire trigger interface into phrase commands for a playback engine. A host pulls an active-low strobe line to open a framing window and, while the window is open, sends a number of pulses on a separate pulse line. The number of pulses is the phrase address. When the strobe is released, the block issues a one-cycle play request with that address. If no pulse arrived during the window, it issues a one-cycle stop request instead.

All three control inputs are asynchronous. Each passes through a synchronizer on the system clock before any edge is detected. A wake input holds the block in standby while it is low, and standby ignores strobe activity. One level pattern is reserved as a reset of the interface and of downstream logic: wake low, strobe low and pulse line high. While the block sees this pattern it raises a clear output.

A burst may arrive while a phrase is playing. Its request then carries the new address and replaces the phrase being played.

Top module: `phrase_sel_if`

## Requirements
- R1: After rst_ni is released, play_req_o, stop_req_o and clr_req_o are 0 and addr_o is 0.
- R2: While the strobe is low and wake is high, each rising edge of the pulse line adds one to the count. On the strobe rising edge the block raises play_req_o for exactly one cycle, with addr_o equal to the pulse count modulo 32.
- R3: The 5-bit count wraps. 32 pulses give address 0, 33 give address 1 and 31 give address 31.
- R4: A strobe window with no pulses ends in a stop_req_o of exactly one cycle and no play_req_o, and addr_o keeps its previous value.
- R5: Every strobe window starts counting from 0, whatever the previous window counted.
- R6: While wake_i is low, strobe windows produce neither play_req_o nor stop_req_o, and addr_o keeps its value.
- R7: While wake_i is low, strobe_ni is low and pulse_i is high, clr_req_o is 1 (after synchronizer delay) and addr_o is cleared to 0.
- R8: A burst that follows a previous play request, with no stop in between, replaces addr_o with the new count.
- R9: play_req_o and stop_req_o are never high in the same cycle. Each of them is high for a single cycle per strobe rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_ni | input | 1 | Asynchronous framing strobe, active low |
| pulse_i | input | 1 | Asynchronous address pulse line |
| wake_i | input | 1 | Asynchronous wake level; low selects standby |
| play_req_o | output | 1 | One-cycle play request |
| stop_req_o | output | 1 | One-cycle stop request |
| addr_o | output | 5 | Latched phrase address |
| clr_req_o | output | 1 | High while the reset pattern is seen |

## Verification
The assertions assume that every high and low phase of the pulse and strobe lines lasts at least two clock cycles. Under that assumption the synchronized strobe can never rise on two consecutive cycles, which is what makes the requests single-cycle. The stimulus holds each pulse phase for two cycles. It also waits several cycles after opening the strobe window and after the last pulse before releasing the strobe, so no pulse edge falls in the same cycle as a strobe edge. When leaving standby, the bench raises the strobe before it raises wake, so no request is produced.

// File: rtl/phrase_sel_pkg.sv
package phrase_sel_pkg;
  localparam int unsigned ADDR_W_DEF = 5;
  localparam int unsigned SYNC_DEF   = 2;
  // synchronized control bundle, bit order fixed for the sync vector
  typedef struct packed {
    logic wake;
    logic strobe_n;
    logic pulse;
  } ctl_t;
  localparam ctl_t CTL_IDLE = '{wake: 1'b0, strobe_n: 1'b1, pulse: 1'b0};
endpackage

// File: rtl/psel_sync.sv
module psel_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_V;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psel_counter.sv
module psel_counter #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              seen_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= inc_i ? ADDR_W'(1) : '0;
      seen_q <= inc_i;
    end else if (inc_i) begin
      cnt_q  <= cnt_q + 1'b1;  // natural wrap
      seen_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign seen_o = seen_q;

  AST_NONZERO_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> seen_q); // R4
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> (cnt_q == '0 && !seen_q)); // R5
endmodule

// File: rtl/phrase_sel_if.sv
module phrase_sel_if
  import phrase_sel_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_ni,
  input  logic              pulse_i,
  input  logic              wake_i,
  output logic              play_req_o,
  output logic              stop_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              clr_req_o
);
  localparam int unsigned CW = $bits(ctl_t);

  ctl_t              ctl_raw, ctl_s;
  logic [CW-1:0]     ctl_vec;
  logic              strobe_q, pulse_q;
  logic              st_rise, st_fall, pi_rise, combo, active, inc, clr;
  logic [ADDR_W-1:0] cnt;
  logic              seen;

  assign ctl_raw = '{wake: wake_i, strobe_n: strobe_ni, pulse: pulse_i};

  psel_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_V(CTL_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_vec)
  );
  assign ctl_s = ctl_t'(ctl_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      pulse_q  <= 1'b0;
    end else begin
      strobe_q <= ctl_s.strobe_n;
      pulse_q  <= ctl_s.pulse;
    end
  end

  assign st_rise = ctl_s.strobe_n & ~strobe_q;
  assign st_fall = ~ctl_s.strobe_n & strobe_q;
  assign pi_rise = ctl_s.pulse & ~pulse_q;
  assign active  = ctl_s.wake;
  assign combo   = ~ctl_s.wake & ~ctl_s.strobe_n & ctl_s.pulse;
  assign inc     = active & ~ctl_s.strobe_n & pi_rise;
  assign clr     = st_fall | ~active;

  psel_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (cnt),
    .seen_o(seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_req_o <= 1'b0;
      stop_req_o <= 1'b0;
      clr_req_o  <= 1'b0;
      addr_o     <= '0;
    end else begin
      play_req_o <= active & st_rise & seen;
      stop_req_o <= active & st_rise & ~seen;
      clr_req_o  <= combo;
      if (active && st_rise && seen) addr_o <= cnt;
      else if (combo)                addr_o <= '0;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(play_req_o && stop_req_o)); // R9
  AST_PLAY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_req_o |=> !play_req_o); // R9
  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |=> !stop_req_o); // R4
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_req_o || stop_req_o) |-> $past(ctl_s.wake)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!play_req_o && !clr_req_o) |-> $stable(addr_o)); // R8
  AST_CLR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |-> (addr_o == '0)); // R7
endmodule

// File: tb/tb_phrase_sel_if.sv
module tb_phrase_sel_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic       pulse = 1'b0;
  logic       wake = 1'b0;
  logic       play_req, stop_req, clr_req;
  logic [4:0] addr;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  int         n_play, n_stop;
  logic [4:0] last_addr;

  always #10 clk = ~clk;

  phrase_sel_if dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_ni(strobe_n), .pulse_i(pulse),
    .wake_i(wake), .play_req_o(play_req), .stop_req_o(stop_req),
    .addr_o(addr), .clr_req_o(clr_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // open window, send n pulses, close, then observe for 8 cycles
  task automatic burst(input int n);
    n_play = 0; n_stop = 0;
    strobe_n = 1'b0; cyc(4);
    for (int i = 0; i < n; i++) begin
      pulse = 1'b1; cyc(2);
      pulse = 1'b0; cyc(2);
    end
    cyc(3);
    strobe_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (play_req) n_play++;
      if (stop_req) n_stop++;
      if (play_req && stop_req) chk(0, "R9 both", 1, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wake = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(6);
    chk(!play_req && !stop_req && !clr_req, "R1 reqs", {play_req, stop_req, clr_req}, 0);
    chk(addr == 0, "R1 addr", addr, 0);

    // R2 / R3 / R5 sweep: each burst counts from 0
    for (int n = 1; n <= 33; n++) begin
      burst(n);
      chk(n_play == 1 && n_stop == 0, "R2 one play", n_play, 1);
      chk(addr == 5'(n % 32), (n >= 31) ? "R3 wrap" : "R5 fresh count", addr, n % 32);
    end

    burst(9);
    burst(4);
    chk(addr == 4, "R8 replace", addr, 4);
    chk(n_play == 1, "R9 single play", n_play, 1);

    // R4 zero pulses
    last_addr = addr;
    burst(0);
    chk(n_stop == 1 && n_play == 0, "R4 stop", n_stop, 1);
    chk(addr == last_addr, "R4 addr kept", addr, last_addr);

    // R6 standby
    burst(6);
    wake = 1'b0; cyc(4);
    last_addr = addr;
    burst(0);
    chk(n_stop == 0 && n_play == 0, "R6 no req", n_stop + n_play, 0);
    chk(addr == last_addr, "R6 addr kept", addr, last_addr);

    // R7 reset pattern
    strobe_n = 1'b0; cyc(2); pulse = 1'b1; cyc(4);
    chk(clr_req == 1'b1, "R7 clr", clr_req, 1);
    chk(addr == 0, "R7 addr cleared", addr, 0);
    pulse = 1'b0; cyc(4);
    chk(clr_req == 1'b0, "R7 clr released", clr_req, 0);
    strobe_n = 1'b1; cyc(4);
    wake = 1'b1; cyc(4);
    chk(!play_req && !stop_req, "R6 wake clean", {play_req, stop_req}, 0);
    burst(12);
    chk(n_play == 1 && addr == 12, "R2 after wake", addr, 12);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule